// File: doc/BRIEF.md
# Symmetric Rounding and Saturation Output Stage

This stage narrows a wide signed accumulator word to a short signed output sample. The wide word carries `FRAC_W` fraction bits. The stage drops them either by plain truncation or by rounding that is symmetric about zero. It then fits the integer part into `OUT_W` bits. On overflow it either clamps to the output limits or keeps only the low bits, so the value wraps.

Negative values receive a bias of one half minus one least significant fraction bit. Non-negative values receive a bias of exactly one half. As a result, ties round away from zero in both directions, which keeps the long-run average error near zero.

Each option is a parameter and costs its own pipeline registers. Rounding adds two cycles and saturation adds one. With both options off, the stage is purely combinational. A valid flag travels alongside the data with the same delay. A clock enable freezes every register in the stage.

Top module: `round_sat_stage`

## Requirements
- R1: While reset (`rst_n` low) is applied, and afterwards until a valid word emerges, `out_vld` is 0. With saturation enabled, `out_dat` reads 0 during reset.
- R2: With rounding on, a non-negative input (zero included) has one half (binary 1 followed by `FRAC_W-1` zeros) added before the fraction bits are dropped. Examples with `FRAC_W`=8: 384 gives 2, 383 gives 1, 128 gives 1, 127 gives 0, and 0 gives 0.
- R3: With rounding on, a negative input has just under one half (binary 0 followed by `FRAC_W-1` ones) added, and the sum is then floored. Examples: -384 gives -2, -383 gives -1, -128 gives -1, -127 gives 0, and -320 gives -1.
- R4: With rounding off, the fraction bits are truncated, which floors the value. Examples: -320 gives -2, 448 gives 1, -1 gives -1, and 255 gives 0.
- R5: With saturation on, a rounded integer outside the signed `OUT_W`-bit range clamps to the nearest limit. Examples with `OUT_W`=8: 127 for positive overflow and -128 for negative overflow.
- R6: With saturation off, the output is the low `OUT_W` bits of the integer part in two's complement. Example: 200 becomes -56.
- R7: Latency in enabled clock edges is 2 when rounding is on plus 1 when saturation is on. `out_vld` follows `in_vld` with that same delay. With both options off, the output follows the input in the same cycle.
- R8: When `ce` is low, no stage register changes, so a registered output and its valid flag hold their values.
- R9: With `ce` held high, one word is accepted on every clock edge, and back-to-back words come out in order on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce | input | 1 | Clock enable; low stalls all registers |
| in_vld | input | 1 | Input word is valid |
| in_acc | input | ACC_W | Wide signed input with FRAC_W fraction bits |
| out_vld | output | 1 | Output sample is valid |
| out_dat | output | OUT_W | Narrowed signed output sample |

## Verification
The embedded assertions check on every cycle the following properties:
- The rounding bias lies between zero and one half, and is strictly below one half for negative inputs.
- Every overflow leaves the saturating register at a limit whose sign matches the overflowing value.
- A low clock enable freezes the registers.
- Reset keeps the valid flag low.

Only the bench's scenarios can show the exact numerical results: tie cases on both sides of zero, truncation flooring, wrap values and clamps that rounding itself triggers. The same holds for the exact latency count and the in-order streaming of consecutive words.

// File: rtl/round_sat_stage.sv
module round_sat_stage #(
  parameter int ACC_W   = 20,
  parameter int FRAC_W  = 8,
  parameter int OUT_W   = 8,
  parameter bit USE_RND = 1'b1,
  parameter bit USE_SAT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             in_vld,
  input  logic [ACC_W-1:0] in_acc,
  output logic             out_vld,
  output logic [OUT_W-1:0] out_dat
);
  // Requires FRAC_W >= 1 and ACC_W - FRAC_W >= OUT_W.
  localparam int INT_W = ACC_W - FRAC_W;
  localparam int RI_W  = INT_W + 1;
  localparam logic [ACC_W:0]   HALF  = (ACC_W+1)'(1) << (FRAC_W - 1);
  localparam logic [OUT_W-1:0] V_MAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] V_MIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W:0] x_ext;
  logic [RI_W-1:0]       rint;
  logic                  rint_vld;

  assign x_ext = {in_acc[ACC_W-1], in_acc};

  generate
    if (USE_RND) begin : g_rnd
      logic signed [ACC_W:0] bias;
      logic signed [ACC_W:0] r1_sum;
      logic                  r1_vld;
      logic [RI_W-1:0]       r2_int;
      logic                  r2_vld;

      assign bias = in_acc[ACC_W-1] ? HALF - 1'b1 : HALF;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r1_sum <= '0;
          r1_vld <= 1'b0;
          r2_int <= '0;
          r2_vld <= 1'b0;
        end else if (ce) begin
          r1_sum <= x_ext + bias;
          r1_vld <= in_vld;
          r2_int <= r1_sum[ACC_W:FRAC_W];
          r2_vld <= r1_vld;
        end
      end

      assign rint     = r2_int;
      assign rint_vld = r2_vld;

      assert_rnd_bias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ce |=> ((r1_sum - $past(x_ext)) >= 0) &&
               ((r1_sum - $past(x_ext)) <= $signed(HALF)) &&
               (!$past(x_ext[ACC_W]) || ((r1_sum - $past(x_ext)) < $signed(HALF))));

      assert_rnd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(r1_sum) && $stable(r2_int) && $stable(r2_vld));
    end else begin : g_trn
      assign rint     = x_ext[ACC_W:FRAC_W];
      assign rint_vld = in_vld;
    end

    if (USE_SAT) begin : g_sat
      logic ovf;
      logic [OUT_W-1:0] o_dat;
      logic             o_vld;

      assign ovf = ~((&rint[RI_W-1:OUT_W-1]) | ~(|rint[RI_W-1:OUT_W-1]));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          o_dat <= '0;
          o_vld <= 1'b0;
        end else if (ce) begin
          o_dat <= ovf ? (rint[RI_W-1] ? V_MIN : V_MAX) : rint[OUT_W-1:0];
          o_vld <= rint_vld;
        end
      end

      assign out_dat = o_dat;
      assign out_vld = o_vld;

      assert_sat_clamp_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ce && ovf |=> ((out_dat == V_MAX) || (out_dat == V_MIN)) &&
                      (out_dat[OUT_W-1] == $past(rint[RI_W-1])));

      assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(out_dat) && $stable(out_vld));

      assert_reset_idle_R1: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (!out_vld && (out_dat == '0)));
    end else begin : g_wrap
      assign out_dat = rint[OUT_W-1:0];
      assign out_vld = rint_vld;
    end
  endgenerate

endmodule

// File: tb/round_sat_stage_tb.sv
`timescale 1ns/1ps
module round_sat_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce;
  logic        in_vld;
  logic [19:0] in_acc;
  logic        a_vld, b_vld;
  logic [7:0]  a_dat, b_dat;
  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  round_sat_stage u_dut (
    .clk(clk), .rst_n(rst_n), .ce(ce), .in_vld(in_vld), .in_acc(in_acc),
    .out_vld(a_vld), .out_dat(a_dat));

  round_sat_stage #(.USE_RND(1'b0), .USE_SAT(1'b0)) u_dut_tw (
    .clk(clk), .rst_n(rst_n), .ce(ce), .in_vld(in_vld), .in_acc(in_acc),
    .out_vld(b_vld), .out_dat(b_dat));

  function automatic logic [7:0] ref_rs(longint x);
    longint q;
    if (x >= 0) q = (x + 128) / 256;
    else        q = -(((-x) + 128) / 256);
    if (q > 127)  q = 127;
    if (q < -128) q = -128;
    return q[7:0];
  endfunction

  function automatic logic [7:0] ref_tw(longint x);
    longint q;
    q = x >>> 8;
    return q[7:0];
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, $signed(act), $signed(exp));
    end
  endtask

  // drive one word; check combinational DUT at once and registered DUT after 3 edges
  task automatic apply(string req, longint x);
    @(negedge clk);
    ce = 1'b1; in_vld = 1'b1; in_acc = x[19:0];
    #1;
    chk({req, " R7 comb vld"}, {7'd0, b_vld}, 8'd1);
    chk(req, b_dat, ref_tw(x));
    @(negedge clk);
    in_vld = 1'b0;
    @(negedge clk);
    chk({req, " R7 vld early"}, {7'd0, a_vld}, 8'd0);
    @(negedge clk);
    chk({req, " R7 vld"}, {7'd0, a_vld}, 8'd1);
    chk(req, a_dat, ref_rs(x));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ce = 1'b1; in_vld = 1'b0; in_acc = '0;
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", {7'd0, a_vld}, 8'd0);
    chk("R1 dat in reset", a_dat, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 vld after reset", {7'd0, a_vld}, 8'd0);
    in_vld = 1'b1; in_acc = 20'd5000;
    @(negedge clk);
    in_vld = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 flush by reset", {7'd0, a_vld}, 8'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 no stale word", {7'd0, a_vld}, 8'd0);
  endtask

  task automatic t_round_pos();
    apply("R2 zero", 0);
    apply("R2 1.5", 384);
    apply("R2 1.496", 383);
    apply("R2 0.5", 128);
    apply("R2 0.496", 127);
  endtask

  task automatic t_round_neg();
    apply("R3 -1.5", -384);
    apply("R3 -1.496", -383);
    apply("R3 -0.5", -128);
    apply("R3 -0.496", -127);
    apply("R3 -1.25", -320);
  endtask

  task automatic t_trunc();
    apply("R4 -1.25", -320);
    apply("R4 1.75", 448);
    apply("R4 -tiny", -1);
    apply("R4 0.996", 255);
  endtask

  task automatic t_sat_wrap();
    apply("R5 R6 +200", 200 * 256);
    apply("R5 R6 -200", -200 * 256);
    apply("R5 round over", 127 * 256 + 128);
    apply("R5 edge", 127 * 256 + 127);
    apply("R5 neg edge", -128 * 256 - 128);
    apply("R5 R6 max", 524287);
    apply("R5 R6 min", -524288);
  endtask

  task automatic t_stream();
    longint v[6] = '{100, -700, 33000, -33000, 640, -1};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i >= 3 && i < 9) begin
        chk("R9 stream vld", {7'd0, a_vld}, 8'd1);
        chk("R9 stream dat", a_dat, ref_rs(v[i-3]));
      end
      if (i == 9) chk("R9 stream end", {7'd0, a_vld}, 8'd0);
      ce = 1'b1;
      if (i < 6) begin in_vld = 1'b1; in_acc = v[i][19:0]; end
      else in_vld = 1'b0;
    end
  endtask

  task automatic t_stall();
    @(negedge clk);
    ce = 1'b1; in_vld = 1'b1; in_acc = 20'(-900);
    @(negedge clk);
    ce = 1'b0; in_vld = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 stalled vld", {7'd0, a_vld}, 8'd0);
    end
    ce = 1'b1;
    @(negedge clk);
    chk("R8 one more edge", {7'd0, a_vld}, 8'd0);
    @(negedge clk);
    chk("R8 vld after stall", {7'd0, a_vld}, 8'd1);
    chk("R8 dat after stall", a_dat, ref_rs(-900));
    ce = 1'b0;
    in_vld = 1'b1; in_acc = 20'd9000;
    repeat (2) @(negedge clk);
    chk("R8 frozen vld", {7'd0, a_vld}, 8'd1);
    chk("R8 frozen dat", a_dat, ref_rs(-900));
    in_vld = 1'b0; ce = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 drained", {7'd0, a_vld}, 8'd0);
  endtask

  initial begin
    t_reset();
    t_round_pos();
    t_round_neg();
    t_trunc();
    t_sat_wrap();
    t_stream();
    t_stall();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule